// File: doc/BRIEF.md
# Streaming Corner-Strength Pipeline

This block turns a raster stream of grayscale pixels, one per clock when a valid strobe is high, into a stream of signed corner-strength values. There is one result for each accepted pixel. The result comes out a fixed number of clocks later, in the same order as the pixels. A start-of-frame marker on the first pixel of each frame resets the raster position. After that the position advances along rows of `IMG_W` pixels. Pixels may arrive with idle cycles between them, and each stage moves forward only when it holds a valid item.

Every window in the pipeline is trailing: it ends at the pixel just accepted, and any sample that lies before column 0 or row 0 of the current frame counts as zero. The pipeline runs in six steps:
- Central differences give the horizontal and vertical gradients.
- The three gradient products are scaled down by an arithmetic shift.
- A five-tap binomial filter smooths each product along the row.
- A second five-tap binomial filter smooths it down the column.
- The determinant and trace are formed from the smoothed values.
- The trace term, scaled by a right shift, is subtracted from the determinant.

All arithmetic is integer. Line buffers inferred as block RAM hold the previous image rows and the previous rows of filtered data.

Top module: `harris_corner`

## Requirements
- R1: Each pixel accepted with `in_valid` high yields exactly one `out_valid` pulse 8 clocks later, in acceptance order. Idle cycles between pixels change neither the count, the order nor the latency.
- R2: A pixel with `in_sof` high is position row 0, column 0. Later pixels advance the column and wrap to column 0 of the next row after column `IMG_W-1`. No data from earlier frames or rows outside the trailing windows affects a result.
- R3: For the pixel at row r, column c, with P(r,c) zero outside the frame or at negative indices, the gradients are gx = P(r-1,c) - P(r-1,c-2) and gy = P(r,c-1) - P(r-2,c-1).
- R4: The products gx*gx, gx*gy and gy*gy are each arithmetically shifted right by `PROD_SHIFT` bits (default 4). This happens before any filtering, and no stage overflows even when pixels are at full scale.
- R5: Each scaled product is filtered along the row with weights 1,4,6,4,1 over columns c, c-1, c-2, c-3 and c-4, and then arithmetically shifted right by `HSHIFT` (default 4). Taps at columns below 0 contribute zero.
- R6: Each row-filtered value is filtered down the column with weights 1,4,6,4,1 over rows r, r-1, r-2, r-3 and r-4, and then arithmetically shifted right by `VSHIFT` (default 4). Taps at rows below 0 contribute zero. The results are Sxx, Sxy and Syy.
- R7: `out_resp` = Sxx*Syy - Sxy*Sxy - ((Sxx+Syy)^2 >>> `K_SHIFT`), with `K_SHIFT` defaulting to 4. The result is presented as a two's-complement value of `OUT_W` bits.
- R8: After reset `out_valid` is 0 and `out_resp` is 0, and `out_resp` holds its last value on every cycle that `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel strobe |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | PIX_W | Unsigned pixel intensity |
| out_valid | output | 1 | Result strobe |
| out_resp | output | OUT_W | Signed corner strength |

## Verification
The assertions check several properties on every cycle:
- the fixed 8-cycle valid latency and the hold of the output between results;
- the column counter staying inside the row;
- zero vertical gradient in column 0 and zero horizontal gradient in row 0, which shows the padding;
- non-negative diagonal smoothed terms;
- line-buffer reads and writes never sharing an address.

The numeric content of the results can only be shown by the bench scenarios, which compare every output against an integer model with the same shifts. Those scenarios cover:
- pseudo-random frames with and without idle gaps;
- a saturated white frame, for overflow;
- vertical stripes, for strong horizontal gradients;
- a frame abandoned part-way through a row and restarted.

// File: rtl/harris_pkg.sv
package harris_pkg;
  localparam int NCH      = 3;   // gradient product channels
  localparam int CH_XX    = 0;
  localparam int CH_XY    = 1;
  localparam int CH_YY    = 2;
  localparam int VROWS    = 4;   // earlier rows kept for the column filter
  localparam int ROW_W    = 3;
  localparam int ROW_SAT  = 4;   // row index saturates: windows look back 4 rows at most
  localparam int PIPE_LAT = 8;   // registers from pixel to result

  typedef logic [ROW_W-1:0] row_t;
endpackage

// File: rtl/harris_linebuf.sv
module harris_linebuf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 640,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/harris_grad.sv
module harris_grad
  import harris_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int IMG_W  = 640,
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int GRAD_W = PIX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic [PIX_W-1:0]         in_pix,
  output logic                     out_valid,
  output logic [COL_W-1:0]         out_col,
  output row_t                     out_row,
  output logic signed [GRAD_W-1:0] out_gx,
  output logic signed [GRAD_W-1:0] out_gy
);
  logic [COL_W-1:0] cnt_col, cur_col;
  row_t             cnt_row, cur_row;

  assign cur_col = in_sof ? '0 : cnt_col;
  assign cur_row = in_sof ? '0 : cnt_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_col <= '0;
      cnt_row <= '0;
    end else if (in_valid) begin
      if (cur_col == COL_W'(IMG_W - 1)) begin
        cnt_col <= '0;
        cnt_row <= (cur_row == row_t'(ROW_SAT)) ? cur_row : cur_row + 1'b1;
      end else begin
        cnt_col <= cur_col + 1'b1;
        cnt_row <= cur_row;
      end
    end
  end

  // stage a: pixel registered beside the synchronous line-buffer read
  logic             a_v;
  logic [PIX_W-1:0] a_pix;
  logic [COL_W-1:0] a_col;
  row_t             a_row;
  logic [2*PIX_W-1:0] lb_q;

  always_ff @(posedge clk) begin
    if (rst) a_v <= 1'b0;
    else     a_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_pix <= in_pix;
      a_col <= cur_col;
      a_row <= cur_row;
    end
  end

  // upper byte: two rows up, lower byte: one row up
  harris_linebuf #(.DATA_W(2*PIX_W), .DEPTH(IMG_W)) u_rows (
    .clk     (clk),
    .rd_en   (in_valid),
    .rd_addr (cur_col),
    .rd_data (lb_q),
    .wr_en   (a_v),
    .wr_addr (a_col),
    .wr_data ({lb_q[PIX_W-1:0], a_pix})
  );

  logic [PIX_W-1:0] col_top, col_mid, col_bot;
  logic [PIX_W-1:0] mid1, mid2, top1, bot1;
  logic [PIX_W-1:0] mid2_m;
  logic signed [GRAD_W-1:0] gx, gy;

  always_comb begin
    col_top = (a_row >= 2) ? lb_q[2*PIX_W-1:PIX_W] : '0;
    col_mid = (a_row >= 1) ? lb_q[PIX_W-1:0] : '0;
    col_bot = a_pix;
    mid2_m  = (a_col >= 2) ? mid2 : '0;
    gx = $signed({1'b0, col_mid}) - $signed({1'b0, mid2_m});
    gy = (a_col >= 1) ? ($signed({1'b0, bot1}) - $signed({1'b0, top1})) : '0;
  end

  always_ff @(posedge clk) begin
    if (a_v) begin
      mid1 <= col_mid;
      mid2 <= mid1;
      top1 <= col_top;
      bot1 <= col_bot;
      out_gx  <= gx;
      out_gy  <= gy;
      out_col <= a_col;
      out_row <= a_row;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= a_v;
  end

  assert_col_in_row_R2: assert property (@(posedge clk) disable iff (rst)
    a_v |-> (int'(a_col) < IMG_W));
  assert_row0_gx_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_row == '0) |-> (out_gx == '0));
  assert_col0_gy_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_col == '0) |-> (out_gy == '0));
  assert_rowbuf_no_clash_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_v) |-> (cur_col != a_col));
endmodule

// File: rtl/harris_smooth.sv
module harris_smooth
  import harris_pkg::*;
#(
  parameter int GRAD_W     = 9,
  parameter int IMG_W      = 640,
  parameter int PROD_SHIFT = 4,
  parameter int HSHIFT     = 4,
  parameter int VSHIFT     = 4,
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int PROD_W = 2 * GRAD_W,
  localparam int H_W    = PROD_W + 4,
  localparam int V_W    = H_W + 4,
  localparam int LB_W   = NCH * VROWS * H_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [COL_W-1:0]         in_col,
  input  row_t                     in_row,
  input  logic signed [GRAD_W-1:0] in_gx,
  input  logic signed [GRAD_W-1:0] in_gy,
  output logic                     out_valid,
  output logic signed [V_W-1:0]    out_sxx,
  output logic signed [V_W-1:0]    out_sxy,
  output logic signed [V_W-1:0]    out_syy
);
  // stage c: scaled products
  logic signed [PROD_W-1:0] prod [NCH];
  logic signed [PROD_W-1:0] c_q  [NCH];
  logic                     c_v;
  logic [COL_W-1:0]         c_col;
  row_t                     c_row;

  always_comb begin
    prod[CH_XX] = in_gx * in_gx;
    prod[CH_XY] = in_gx * in_gy;
    prod[CH_YY] = in_gy * in_gy;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int ch = 0; ch < NCH; ch++) c_q[ch] <= prod[ch] >>> PROD_SHIFT;
      c_col <= in_col;
      c_row <= in_row;
    end
  end

  // stage d: row-filtered values; stage e: column-filtered values
  logic                  d_v;
  logic [COL_W-1:0]      d_col;
  row_t                  d_row;
  logic signed [H_W-1:0] d_h [NCH];
  logic signed [V_W-1:0] e_s [NCH];
  logic [LB_W-1:0]       lb_q, lb_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_v <= 1'b0;
      d_v <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      c_v <= in_valid;
      d_v <= c_v;
      out_valid <= d_v;
    end
  end

  always_ff @(posedge clk) begin
    if (c_v) begin
      d_col <= c_col;
      d_row <= c_row;
    end
  end

  harris_linebuf #(.DATA_W(LB_W), .DEPTH(IMG_W)) u_hrows (
    .clk     (clk),
    .rd_en   (c_v),
    .rd_addr (c_col),
    .rd_data (lb_q),
    .wr_en   (d_v),
    .wr_addr (d_col),
    .wr_data (lb_wdata)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic signed [PROD_W-1:0] hq1, hq2, hq3, hq4;
    logic signed [H_W-1:0]    t0, t1, t2, t3, t4, hsum;
    logic signed [H_W-1:0]    e0, e1, e2, e3;
    logic signed [V_W-1:0]    u0, u1, u2, u3, u4, vsum;

    always_ff @(posedge clk) begin
      if (c_v) begin
        hq1 <= c_q[ch];
        hq2 <= hq1;
        hq3 <= hq2;
        hq4 <= hq3;
        d_h[ch] <= hsum >>> HSHIFT;
      end
    end

    always_comb begin
      t0 = H_W'(c_q[ch]);
      t1 = (c_col >= 1) ? H_W'(hq1) : '0;
      t2 = (c_col >= 2) ? H_W'(hq2) : '0;
      t3 = (c_col >= 3) ? H_W'(hq3) : '0;
      t4 = (c_col >= 4) ? H_W'(hq4) : '0;
      hsum = t0 + t4 + ((t1 + t3) <<< 2) + (t2 <<< 2) + (t2 <<< 1);
    end

    // entry 0 is the row just above, entry 3 is four rows up
    assign e0 = $signed(lb_q[(ch*VROWS+0)*H_W +: H_W]);
    assign e1 = $signed(lb_q[(ch*VROWS+1)*H_W +: H_W]);
    assign e2 = $signed(lb_q[(ch*VROWS+2)*H_W +: H_W]);
    assign e3 = $signed(lb_q[(ch*VROWS+3)*H_W +: H_W]);

    assign lb_wdata[(ch*VROWS+0)*H_W +: H_W] = d_h[ch];
    assign lb_wdata[(ch*VROWS+1)*H_W +: H_W] = e0;
    assign lb_wdata[(ch*VROWS+2)*H_W +: H_W] = e1;
    assign lb_wdata[(ch*VROWS+3)*H_W +: H_W] = e2;

    always_comb begin
      u0 = V_W'(d_h[ch]);
      u1 = (d_row >= 1) ? V_W'(e0) : '0;
      u2 = (d_row >= 2) ? V_W'(e1) : '0;
      u3 = (d_row >= 3) ? V_W'(e2) : '0;
      u4 = (d_row >= 4) ? V_W'(e3) : '0;
      vsum = u0 + u4 + ((u1 + u3) <<< 2) + (u2 <<< 2) + (u2 <<< 1);
    end

    always_ff @(posedge clk) begin
      if (d_v) e_s[ch] <= vsum >>> VSHIFT;
    end
  end

  assign out_sxx = e_s[CH_XX];
  assign out_sxy = e_s[CH_XY];
  assign out_syy = e_s[CH_YY];

  assert_diag_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!out_sxx[V_W-1] && !out_syy[V_W-1]));
  assert_hrowbuf_no_clash_R6: assert property (@(posedge clk) disable iff (rst)
    (c_v && d_v) |-> (c_col != d_col));
endmodule

// File: rtl/harris_resp.sv
module harris_resp #(
  parameter int V_W     = 26,
  parameter int K_SHIFT = 4,
  parameter int OUT_W   = 32,
  localparam int P_W    = 2 * V_W,
  localparam int DET_W  = P_W + 1,
  localparam int TR_W   = V_W + 1,
  localparam int T2_W   = 2 * TR_W,
  localparam int RF_W   = T2_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [V_W-1:0]   in_sxx,
  input  logic signed [V_W-1:0]   in_sxy,
  input  logic signed [V_W-1:0]   in_syy,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_resp
);
  logic                    f_v, g_v;
  logic signed [P_W-1:0]   p_diag, p_cross;
  logic signed [TR_W-1:0]  tr;
  logic signed [DET_W-1:0] det;
  logic signed [T2_W-1:0]  tr_sq;
  logic signed [RF_W-1:0]  resp_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_v <= 1'b0;
      g_v <= 1'b0;
      out_valid <= 1'b0;
      out_resp  <= '0;
    end else begin
      f_v <= in_valid;
      g_v <= f_v;
      out_valid <= g_v;
      if (g_v) out_resp <= OUT_W'(resp_full);
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      p_diag  <= in_sxx * in_syy;
      p_cross <= in_sxy * in_sxy;
      tr      <= TR_W'(in_sxx) + TR_W'(in_syy);
    end
    if (f_v) begin
      det   <= DET_W'(p_diag) - DET_W'(p_cross);
      tr_sq <= tr * tr;
    end
  end

  assign resp_full = RF_W'(det) - RF_W'(tr_sq >>> K_SHIFT);
endmodule

// File: rtl/harris_corner.sv
module harris_corner
  import harris_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int IMG_W      = 640,
  parameter int PROD_SHIFT = 4,
  parameter int HSHIFT     = 4,
  parameter int VSHIFT     = 4,
  parameter int K_SHIFT    = 4,
  parameter int OUT_W      = 32,
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int GRAD_W = PIX_W + 1,
  localparam int V_W    = 2 * GRAD_W + 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_resp
);
  logic                     g_v, s_v;
  logic [COL_W-1:0]         g_col;
  row_t                     g_row;
  logic signed [GRAD_W-1:0] g_x, g_y;
  logic signed [V_W-1:0]    s_xx, s_xy, s_yy;
  logic signed [OUT_W-1:0]  resp;

  harris_grad #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_grad (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .out_valid(g_v), .out_col(g_col), .out_row(g_row), .out_gx(g_x), .out_gy(g_y)
  );

  harris_smooth #(.GRAD_W(GRAD_W), .IMG_W(IMG_W), .PROD_SHIFT(PROD_SHIFT),
                  .HSHIFT(HSHIFT), .VSHIFT(VSHIFT)) u_smooth (
    .clk(clk), .rst(rst), .in_valid(g_v), .in_col(g_col), .in_row(g_row),
    .in_gx(g_x), .in_gy(g_y),
    .out_valid(s_v), .out_sxx(s_xx), .out_sxy(s_xy), .out_syy(s_yy)
  );

  harris_resp #(.V_W(V_W), .K_SHIFT(K_SHIFT), .OUT_W(OUT_W)) u_resp (
    .clk(clk), .rst(rst), .in_valid(s_v),
    .in_sxx(s_xx), .in_sxy(s_xy), .in_syy(s_yy),
    .out_valid(out_valid), .out_resp(resp)
  );

  assign out_resp = resp;

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                              since_rst <= '0;
    else if (since_rst != 4'(PIPE_LAT))   since_rst <= since_rst + 1'b1;
  end

  assert_fixed_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 4'(PIPE_LAT)) |-> (out_valid == $past(in_valid, 8)));
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_resp));
endmodule

// File: tb/sim_harris_corner.sv
`timescale 1ns/1ps
module sim_harris_corner;
  localparam int W   = 16;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_pix = '0;
  logic        out_valid;
  logic [31:0] out_resp;

  harris_corner #(.IMG_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .out_valid(out_valid), .out_resp(out_resp)
  );

  always #4 clk = ~clk;

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  int     img [0:15][0:15];
  int     pr = 0, pc = 0;
  int     pushed = 0, popped = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] last_out = '0;

  longint exp_q [$];
  longint t_q   [$];
  string  tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint pix_at(int r, int c);
    if (r < 0 || c < 0) return 0;
    return longint'(img[r][c]);
  endfunction

  function automatic longint wt(int k);
    if (k == 2) return 6;
    if (k == 1 || k == 3) return 4;
    return 1;
  endfunction

  function automatic longint qv(int ch, int r, int c);
    longint x, y, p;
    x = pix_at(r-1, c) - pix_at(r-1, c-2);
    y = pix_at(r, c-1) - pix_at(r-2, c-1);
    p = (ch == 0) ? x*x : (ch == 1) ? x*y : y*y;
    return p >>> 4;
  endfunction

  function automatic longint hv(int ch, int r, int c);
    longint s = 0;
    for (int k = 0; k < 5; k++) if (c - k >= 0) s += wt(k) * qv(ch, r, c-k);
    return s >>> 4;
  endfunction

  function automatic longint vv(int ch, int r, int c);
    longint s = 0;
    for (int k = 0; k < 5; k++) if (r - k >= 0) s += wt(k) * hv(ch, r-k, c);
    return s >>> 4;
  endfunction

  function automatic longint model(int r, int c);
    longint a, b, d, tr;
    a = vv(0, r, c); b = vv(1, r, c); d = vv(2, r, c);
    tr = a + d;
    return a*d - b*b - ((tr*tr) >>> 4);
  endfunction

  task automatic send(input logic [7:0] p, input logic sof, input string tag);
    @(negedge clk);
    if (sof) begin pr = 0; pc = 0; end
    in_valid = 1'b1; in_sof = sof; in_pix = p;
    img[pr][pc] = int'(p);
    exp_q.push_back(model(pr, pc));
    t_q.push_back(cyc);
    if (pr < 4)      tag_q.push_back("R6");
    else if (pc < 4) tag_q.push_back("R5");
    else             tag_q.push_back(tag);
    pushed++;
    if (pc == W - 1) begin pc = 0; pr++; end else pc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;
    end
  endtask

  function automatic logic [7:0] pattern(int kind, int r, int c);
    case (kind)
      0: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; return lfsr[7:0]; end
      1: return 8'd255;
      2: return ((c % 4) < 2) ? 8'd200 : 8'd10;
      default: return 8'((r * 16 + c * 8) & 255);
    endcase
  endfunction

  task automatic frame(input int rows, input int kind, input bit gaps, input string tag);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < W; c++) begin
        send(pattern(kind, r, c), (r == 0 && c == 0), tag);
        if (gaps && ((r * W + c) % 3 == 1)) idle((c % 3) + 1);
      end
    idle(1);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", 1, 0);
      end else begin
        longint e, t;
        string  g;
        e = exp_q.pop_front(); t = t_q.pop_front(); g = tag_q.pop_front();
        popped++;
        check(cyc - t == LAT, "R1", cyc - t, LAT);
        check(longint'($signed(out_resp)) == e, g, longint'($signed(out_resp)), e);
        last_out = out_resp;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      check(1'b0, "R1", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    // R8: state after reset
    check(out_valid == 1'b0, "R8", out_valid, 0);
    check(out_resp == '0, "R8", out_resp, 0);
    rst = 1'b0;
    idle(3);
    frame(8, 0, 1'b0, "R7");
    frame(8, 0, 1'b1, "R1");
    frame(6, 1, 1'b0, "R4");
    frame(6, 2, 1'b0, "R3");
    // R2: abandon a frame part-way through a row, then restart
    for (int i = 0; i < 20; i++) send(pattern(0, 0, i), (i == 0), "R2");
    idle(2);
    frame(6, 3, 1'b0, "R2");
    idle(20);
    // R8: output holds its last value while idle
    check(out_valid == 1'b0, "R8", out_valid, 0);
    check(out_resp == last_out, "R8", out_resp, last_out);
    // R1: one result for every pixel
    check(popped == pushed, "R1", popped, pushed);
    check(exp_q.size() == 0, "R1", exp_q.size(), 0);
    finish_run();
  end
endmodule